// File: doc/BRIEF.md
# Range Coder Byte Renormalizer

This stage sits after the interval update of a binary range encoder. For each coded symbol it receives the low bound, the range width and the upper bound `low + range` as 32-bit words. It decides whether one byte of code can be released, shifts the registers to match, and hands the shifted low bound and range back for the next symbol. At most one code byte leaves per symbol.

The decision is a single step and never a loop. If the top bytes of the low and upper bounds agree, that byte is settled: it is emitted, and both low and range move up by one byte. If they disagree but the range has fallen below 2^16, the range is cut down to the distance from low to the next 2^16 boundary, `(-low) mod 2^16`, so that the top byte becomes settled. That byte is then emitted and the same one-byte shift is applied. Otherwise the registers pass through untouched. Because the range is never allowed to reach zero, one step per symbol keeps the coder in its working window.

All results are registered. A symbol presented with `symValid` high produces its outputs on the next rising clock edge.

Top module: `byte_renorm`

## Requirements
- R1: When `symValid` is high and `lowIn[31:24] == highIn[31:24]`, the next edge sets `byteValid` to 1, `byteOut` to `lowIn[31:24]`, `lowOut` to `lowIn << 8` and `rangeOut` to `rangeIn << 8`.
- R2: When `symValid` is high, the top bytes of `lowIn` and `highIn` differ and `rangeIn[31:16] == 0`, the next edge sets `byteValid` to 1, `byteOut` to `lowIn[31:24]`, `lowOut` to `lowIn << 8` and `rangeOut` to `(((~lowIn) + 1) & 32'h0000FFFF) << 8`.
- R3: When `symValid` is high, the top bytes differ and `rangeIn[31:16] != 0`, the next edge sets `byteValid` to 0 and copies `lowIn` to `lowOut` and `rangeIn` to `rangeOut` unchanged.
- R4: The top-byte test takes priority over the range test. When both conditions hold, the range is shifted as given and is not replaced.
- R5: On a cycle with `symValid` low, the next edge sets `byteValid` to 0 and leaves `lowOut`, `rangeOut` and `byteOut` at their previous values.
- R6: While `rstN` is low, `byteValid`, `byteOut`, `lowOut` and `rangeOut` are all 0.
- R7: Every shift drops the bits that pass bit 31 and fills the vacated low 8 bits with zeros. Whenever `byteValid` is 1, `lowOut[7:0]` and `rangeOut[7:0]` are 0.
- R8: Each symbol yields at most one byte, one clock edge after it is presented. Back-to-back symbols produce back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| symValid | input | 1 | A coded symbol's registers are present this cycle |
| lowIn | input | 32 | Low bound after interval update |
| rangeIn | input | 32 | Range width after interval update |
| highIn | input | 32 | Upper bound, low plus range |
| lowOut | output | 32 | Renormalized low bound |
| rangeOut | output | 32 | Renormalized range width |
| byteValid | output | 1 | Code byte valid strobe |
| byteOut | output | 8 | Code byte |

## Verification
A wrong decision in the control shows on the very next edge. A missing or extra `byteValid`, a range left unclamped, or low and range shifted when they should have passed through each appears as a one-cycle discrepancy on `lowOut`, `rangeOut` or the byte interface. Because the stage keeps no state beyond its output registers, a fault cannot hide for several cycles. Even so, a hold fault on an idle cycle only shows when the held value is compared against the previous result, so idle cycles are checked against the last output. The priority between the two conditions is only visible with inputs where both hold, so such inputs are applied on purpose.

// File: rtl/byte_renorm_pkg.sv
package byte_renorm_pkg;

  // Strobes from the control to the datapath for one symbol
  typedef struct packed {
    logic load;       // register the new low/range values
    logic shiftByte;  // release top byte of low and shift by a byte
    logic clampRange; // replace range by distance to next boundary
  } renormCtl_t;

endpackage

// File: rtl/byte_renorm_ctrl.sv
module byte_renorm_ctrl
  import byte_renorm_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int LIMIT_W = 16
) (
  input  logic              symValid,
  input  logic [WORD_W-1:0] lowIn,
  input  logic [WORD_W-1:0] rangeIn,
  input  logic [WORD_W-1:0] highIn,
  output renormCtl_t        ctl
);

  localparam int TOP_LSB = WORD_W - BYTE_W;

  logic topSettled;
  logic rangeNarrow;

  // only the leading bytes of the two bounds are compared
  assign topSettled  = (lowIn[WORD_W-1:TOP_LSB] == highIn[WORD_W-1:TOP_LSB]);
  assign rangeNarrow = (rangeIn[WORD_W-1:LIMIT_W] == '0);

  always_comb begin
    ctl            = '0;
    ctl.load       = symValid;
    if (symValid) begin
      if (topSettled) begin
        ctl.shiftByte = 1'b1;
      end else if (rangeNarrow) begin
        ctl.shiftByte  = 1'b1;
        ctl.clampRange = 1'b1;
      end
    end
  end

endmodule

// File: rtl/byte_renorm_dpath.sv
module byte_renorm_dpath
  import byte_renorm_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int LIMIT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  renormCtl_t        ctl,
  input  logic [WORD_W-1:0] lowIn,
  input  logic [WORD_W-1:0] rangeIn,
  output logic [WORD_W-1:0] lowOut,
  output logic [WORD_W-1:0] rangeOut,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteOut
);

  localparam int TOP_LSB = WORD_W - BYTE_W;
  localparam logic [WORD_W-1:0] LIMIT_MASK = {{(WORD_W-LIMIT_W){1'b0}}, {LIMIT_W{1'b1}}};

  logic [WORD_W-1:0] gapToBoundary;
  logic [WORD_W-1:0] rangeSel;
  logic [WORD_W-1:0] lowNext;
  logic [WORD_W-1:0] rangeNext;

  assign gapToBoundary = ((~lowIn) + {{(WORD_W-1){1'b0}}, 1'b1}) & LIMIT_MASK;
  assign rangeSel      = ctl.clampRange ? gapToBoundary : rangeIn;
  assign lowNext       = ctl.shiftByte ? (lowIn << BYTE_W) : lowIn;
  assign rangeNext     = ctl.shiftByte ? (rangeSel << BYTE_W) : rangeIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowOut    <= '0;
      rangeOut  <= '0;
      byteValid <= 1'b0;
      byteOut   <= '0;
    end else begin
      byteValid <= ctl.shiftByte;
      if (ctl.load) begin
        lowOut   <= lowNext;
        rangeOut <= rangeNext;
      end
      if (ctl.shiftByte) begin
        byteOut <= lowIn[WORD_W-1:TOP_LSB];
      end
    end
  end

endmodule

// File: rtl/byte_renorm.sv
module byte_renorm
  import byte_renorm_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int LIMIT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              symValid,
  input  logic [WORD_W-1:0] lowIn,
  input  logic [WORD_W-1:0] rangeIn,
  input  logic [WORD_W-1:0] highIn,
  output logic [WORD_W-1:0] lowOut,
  output logic [WORD_W-1:0] rangeOut,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteOut
);

  renormCtl_t ctl;

  byte_renorm_ctrl #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .LIMIT_W(LIMIT_W)) uCtrl (
    .symValid (symValid),
    .lowIn    (lowIn),
    .rangeIn  (rangeIn),
    .highIn   (highIn),
    .ctl      (ctl)
  );

  byte_renorm_dpath #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .LIMIT_W(LIMIT_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .lowIn     (lowIn),
    .rangeIn   (rangeIn),
    .lowOut    (lowOut),
    .rangeOut  (rangeOut),
    .byteValid (byteValid),
    .byteOut   (byteOut)
  );

endmodule

// File: rtl/byte_renorm_checker.sv
module byte_renorm_checker #(
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int LIMIT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              symValid,
  input logic [WORD_W-1:0] lowIn,
  input logic [WORD_W-1:0] rangeIn,
  input logic [WORD_W-1:0] highIn,
  input logic [WORD_W-1:0] lowOut,
  input logic [WORD_W-1:0] rangeOut,
  input logic              byteValid,
  input logic [BYTE_W-1:0] byteOut
);

  localparam int TOP_LSB = WORD_W - BYTE_W;
  localparam logic [WORD_W-1:0] LIMIT_MASK = {{(WORD_W-LIMIT_W){1'b0}}, {LIMIT_W{1'b1}}};

  logic sameTop;
  logic narrow;
  assign sameTop = (lowIn[WORD_W-1:TOP_LSB] == highIn[WORD_W-1:TOP_LSB]);
  assign narrow  = (rangeIn[WORD_W-1:LIMIT_W] == '0);

  assert_settled_emit_R1: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && sameTop) |=> (byteValid && byteOut == $past(lowIn[WORD_W-1:TOP_LSB])
                               && lowOut == ($past(lowIn) << BYTE_W)));

  assert_clamp_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && !sameTop && narrow) |=> (byteValid &&
      rangeOut == (((~$past(lowIn)) + 1) & LIMIT_MASK) << BYTE_W));

  assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && !sameTop && !narrow) |=> (!byteValid && lowOut == $past(lowIn)
                                            && rangeOut == $past(rangeIn)));

  assert_top_priority_R4: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && sameTop && narrow) |=> (rangeOut == ($past(rangeIn) << BYTE_W)));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> (!byteValid && $stable(lowOut) && $stable(rangeOut) && $stable(byteOut)));

  assert_reset_quiet_R6: assert property (@(posedge clk)
    !rstN |-> (!byteValid && lowOut == '0 && rangeOut == '0));

  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (lowOut[BYTE_W-1:0] == '0 && rangeOut[BYTE_W-1:0] == '0));

endmodule

bind byte_renorm byte_renorm_checker #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .LIMIT_W(LIMIT_W)) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .symValid  (symValid),
  .lowIn     (lowIn),
  .rangeIn   (rangeIn),
  .highIn    (highIn),
  .lowOut    (lowOut),
  .rangeOut  (rangeOut),
  .byteValid (byteValid),
  .byteOut   (byteOut)
);

// File: tb/byte_renorm_test.sv
`timescale 1ns/1ps
module byte_renorm_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        symValid = 1'b0;
  logic [31:0] lowIn = '0;
  logic [31:0] rangeIn = '0;
  logic [31:0] highIn = '0;
  logic [31:0] lowOut;
  logic [31:0] rangeOut;
  logic        byteValid;
  logic [7:0]  byteOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  byte_renorm uut (
    .clk(clk), .rstN(rstN), .symValid(symValid),
    .lowIn(lowIn), .rangeIn(rangeIn), .highIn(highIn),
    .lowOut(lowOut), .rangeOut(rangeOut),
    .byteValid(byteValid), .byteOut(byteOut)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // present one symbol at a falling edge, sample after the next rising edge
  task automatic present(input logic [31:0] l, input logic [31:0] r, input logic [31:0] h);
    @(negedge clk);
    symValid = 1'b1; lowIn = l; rangeIn = r; highIn = h;
    @(posedge clk);
    #1;
    symValid = 1'b0;
  endtask

  task automatic expectOut(input string tag, input logic v, input logic [7:0] b,
                           input logic [31:0] l, input logic [31:0] r);
    check(tag, "byteValid", {31'b0, byteValid}, {31'b0, v});
    if (v) check(tag, "byteOut", {24'b0, byteOut}, {24'b0, b});
    check(tag, "lowOut", lowOut, l);
    check(tag, "rangeOut", rangeOut, r);
  endtask

  task automatic test_reset_r6;
    #1;
    expectOut("R6", 1'b0, 8'h00, 32'h0, 32'h0);
    check("R6", "byteOut", {24'b0, byteOut}, 32'h0);
  endtask

  task automatic test_settled_r1;
    present(32'hA1B2C3D4, 32'h12345678, 32'hA1FF0000);
    expectOut("R1", 1'b1, 8'hA1, 32'hB2C3D400, 32'h34567800);
  endtask

  task automatic test_clamp_r2;
    present(32'h12FFFF00, 32'h0000FFFF, 32'h13000000);
    expectOut("R2", 1'b1, 8'h12, 32'hFFFF0000, 32'h00010000);
  endtask

  task automatic test_pass_r3;
    present(32'h12340000, 32'h00010000, 32'h13000000);
    expectOut("R3", 1'b0, 8'h00, 32'h12340000, 32'h00010000);
  endtask

  task automatic test_priority_r4;
    present(32'h55667788, 32'h0000ABCD, 32'h55000000);
    expectOut("R4", 1'b1, 8'h55, 32'h66778800, 32'h00ABCD00);
  endtask

  task automatic test_idle_r5;
    present(32'h0F0F0F0F, 32'h01020304, 32'h0F100000);
    expectOut("R5", 1'b1, 8'h0F, 32'h0F0F0F00, 32'h02030400);
    // idle cycles with noise on the data inputs
    @(negedge clk);
    lowIn = 32'hDEADBEEF; rangeIn = 32'h00000001; highIn = 32'hDEADBEEF;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1;
      expectOut("R5", 1'b0, 8'h00, 32'h0F0F0F00, 32'h02030400);
      check("R5", "byteOut held", {24'b0, byteOut}, 32'h0F);
    end
  endtask

  task automatic test_wrap_r7;
    present(32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFF000000);
    expectOut("R7", 1'b1, 8'hFF, 32'hFFFFFF00, 32'hFFFFFF00);
    present(32'h80000001, 32'h0000FFFF, 32'h81000000);
    expectOut("R7", 1'b1, 8'h80, 32'h00000100, 32'h00FFFF00);
  endtask

  task automatic test_stream_r8;
    @(negedge clk);
    symValid = 1'b1; lowIn = 32'h11223344; rangeIn = 32'h00100000; highIn = 32'h11332244;
    @(negedge clk);
    expectOut("R8", 1'b1, 8'h11, 32'h22334400, 32'h10000000);
    lowIn = 32'h22000000; rangeIn = 32'h10000000; highIn = 32'h32000000;
    @(negedge clk);
    expectOut("R8", 1'b0, 8'h00, 32'h22000000, 32'h10000000);
    lowIn = 32'h2300FF00; rangeIn = 32'h0000FFFF; highIn = 32'h2400FEFF;
    @(negedge clk);
    expectOut("R8", 1'b1, 8'h23, 32'h00FF0000, 32'h00010000);
    symValid = 1'b0;
    @(negedge clk);
    check("R8", "byteValid after stream", {31'b0, byteValid}, 32'h0);
  endtask

  task automatic test_reset_again_r6;
    present(32'h77000000, 32'h00000100, 32'h77000100);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    expectOut("R6", 1'b0, 8'h00, 32'h0, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    test_reset_r6();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_settled_r1();
    test_clamp_r2();
    test_pass_r3();
    test_priority_r4();
    test_idle_r5();
    test_wrap_r7();
    test_stream_r8();
    test_reset_again_r6();
    test_settled_r1();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule